// File: doc/BRIEF.md
# Virtual Line Printer Channel Controller

This block sits between a processor I/O channel and host software that does the actual printing. Each cycle it may receive one channel command: a 3-bit function code and a 5-bit modifier. Initiate-write and control commands are logged in a last-function register that software polls. The register holds the function code, the modifier, a decoded carriage request (space count or skip-to-channel number) and a new-request flag. Software finishes a request by pulsing a completion strobe. The block then clears the flag, raises an interrupt and sets completion bits in its device status word.

A sense command is answered from the status word and never reaches the last-function register. A sense with the reset modifier bit clears the status word and drops the interrupt. The interrupt otherwise stays asserted. If a second request arrives while one is still pending, the block sets a busy bit and leaves the register alone. A skip to a carriage-tape channel outside 1 to 12 is rejected and flagged in the status word.

Top module: `vlp_printer_ctrl`

## Requirements
- R1: Function codes are 3 bits: 101 is initiate write, 100 is control, 111 is sense. Any other code has no effect on the register, the status word, the interrupt or the sense outputs.
- R2: An accepted write or control command sets `lf_new` and presents its function and 5-bit modifier on `lf_func`/`lf_mod`. This happens on the clock edge where the command is sampled.
- R3: A sense command is never logged: `lf_new`, `lf_func` and `lf_mod` keep their values.
- R4: A `sw_done` pulse while `lf_new` is set clears `lf_new` and sets `irq` at the same edge. A `sw_done` pulse with no request pending has no effect.
- R5: A completed write sets status bit 0 (transfer complete) and bit 1 (print complete). A completed control command sets bit 2 (carriage complete).
- R6: On the edge that samples a sense command, `sense_valid` rises for one cycle and `sense_dsw` carries the status word as it was before that command. Modifier bit 0 = 1 then clears every status bit and `irq`. Modifier bit 0 = 0 leaves both unchanged.
- R7: Once set, `irq` stays high until a sense with modifier bit 0 = 1.
- R8: A write or control command arriving while `lf_new` is set sets status bit 3 (busy) and leaves the register unchanged.
- R9: For control, modifier bit 4 = 0 means space by count bits 3:0, giving `carr_skip`=0 and `carr_num`=count. Bit 4 = 1 means skip to channel bits 3:0. A channel from 1 to 12 gives `carr_skip`=1 and `carr_num`=channel. Any other channel sets status bit 4 (bad channel), is not logged and raises no interrupt. A write gives `carr_skip`=0 and `carr_num`=0.
- R10: After reset, `lf_new`, `irq`, `sense_valid`, `sense_dsw`, `lf_func`, `lf_mod` and the carriage outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Channel command present this cycle |
| cmd_func | input | 3 | Function code |
| cmd_mod | input | 5 | Modifier field |
| sw_done | input | 1 | Completion strobe from software |
| lf_new | output | 1 | Last-function register holds an unserved request |
| lf_func | output | 3 | Logged function code |
| lf_mod | output | 5 | Logged modifier |
| carr_skip | output | 1 | Logged carriage request is a skip to channel |
| carr_num | output | 4 | Space count or channel number |
| irq | output | 1 | Interrupt request |
| sense_valid | output | 1 | Sense response strobe |
| sense_dsw | output | 16 | Device status word returned by sense |

## Verification
Every pair of the 8 function codes and 32 modifiers is sent to the block from a cleared state. For each accepted request, completion is signalled and the status word is read back twice: once with a plain sense and once with a resetting sense. This separates the write, control and ignored codes. It also separates space from skip, and in-range channels from rejected ones. It confirms that sense codes never reach the register, and that only the resetting sense drops the interrupt. Separate sequences send a request while another is still pending, and send a completion strobe with nothing pending. These check the busy bit and that the stray completion is ignored.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
   localparam int FN_W = 3;
   typedef logic [FN_W-1:0] fn_t;
   localparam fn_t FN_CTRL  = 3'b100;
   localparam fn_t FN_WRITE = 3'b101;
   localparam fn_t FN_SENSE = 3'b111;

   localparam int ST_XFER  = 0;
   localparam int ST_PRINT = 1;
   localparam int ST_CARR  = 2;
   localparam int ST_BUSY  = 3;
   localparam int ST_CHAN  = 4;
   localparam int ST_MIN_W = 5;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_CTRL  = 2'd2
   } kind_e;
endpackage

// File: rtl/vlp_cmd_decode.sv
module vlp_cmd_decode
   import vlp_pkg::*;
#(
   parameter int MOD_W = 5,
   parameter int NCHAN = 12
) (
   input  logic             cmd_valid,
   input  fn_t              cmd_func,
   input  logic [MOD_W-1:0] cmd_mod,
   output logic             req_write,
   output logic             req_ctrl,
   output logic             req_sense,
   output logic             sense_clr,
   output logic             chan_bad,
   output logic             ctrl_skip,
   output logic [MOD_W-2:0] ctrl_val
);
   localparam int VAL_W = MOD_W - 1;
   localparam logic [VAL_W-1:0] CHAN_MAX = VAL_W'(NCHAN);

   logic ctrl_any;

   always_comb begin
      ctrl_skip = cmd_mod[MOD_W-1];
      ctrl_val  = cmd_mod[VAL_W-1:0];
      req_write = cmd_valid && (cmd_func == FN_WRITE);
      ctrl_any  = cmd_valid && (cmd_func == FN_CTRL);
      req_sense = cmd_valid && (cmd_func == FN_SENSE);
      sense_clr = req_sense && cmd_mod[0];
      chan_bad  = ctrl_any && ctrl_skip &&
                  ((ctrl_val == '0) || (ctrl_val > CHAN_MAX));
      req_ctrl  = ctrl_any && !chan_bad;
   end
endmodule

// File: rtl/vlp_func_reg.sv
module vlp_func_reg
   import vlp_pkg::*;
#(
   parameter int MOD_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_write,
   input  logic             req_ctrl,
   input  logic             req_sense,
   input  logic [MOD_W-1:0] cmd_mod,
   input  logic             ctrl_skip,
   input  logic [MOD_W-2:0] ctrl_val,
   input  logic             sw_done,
   output logic             lf_new,
   output fn_t              lf_func,
   output logic [MOD_W-1:0] lf_mod,
   output logic             carr_skip,
   output logic [MOD_W-2:0] carr_num,
   output logic             busy_hit,
   output logic             done_write,
   output logic             done_ctrl
);
   kind_e kind_q;
   logic  req_any, accept, done_evt;

   always_comb begin
      req_any    = req_write || req_ctrl;
      accept     = req_any && !lf_new;
      busy_hit   = req_any && lf_new;
      done_evt   = sw_done && lf_new;
      done_write = done_evt && (kind_q == KIND_WRITE);
      done_ctrl  = done_evt && (kind_q == KIND_CTRL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lf_new    <= 1'b0;
         lf_func   <= '0;
         lf_mod    <= '0;
         carr_skip <= 1'b0;
         carr_num  <= '0;
         kind_q    <= KIND_NONE;
      end else if (accept) begin
         lf_new    <= 1'b1;
         lf_func   <= req_write ? FN_WRITE : FN_CTRL;
         lf_mod    <= cmd_mod;
         carr_skip <= req_ctrl && ctrl_skip;
         carr_num  <= req_ctrl ? ctrl_val : '0;
         kind_q    <= req_write ? KIND_WRITE : KIND_CTRL;
      end else if (done_evt) begin
         lf_new    <= 1'b0;
      end
   end

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lf_new && !sw_done) |=> (lf_new && $stable(lf_func) && $stable(lf_mod))); // R8
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lf_new && sw_done) |=> !lf_new); // R4
   AST_SENSE_UNLOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_sense && !sw_done) |=> ($stable(lf_new) && $stable(lf_func))); // R3
endmodule

// File: rtl/vlp_status.sv
module vlp_status
   import vlp_pkg::*;
#(
   parameter int DSW_W         = 16,
   parameter bit SENSE_REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_write,
   input  logic             done_ctrl,
   input  logic             busy_hit,
   input  logic             chan_bad,
   input  logic             req_sense,
   input  logic             sense_clr,
   output logic             irq,
   output logic             sense_valid,
   output logic [DSW_W-1:0] sense_dsw
);
   logic [DSW_W-1:0] st_q, st_d;
   logic             irq_d;

   always_comb begin
      st_d  = st_q;
      irq_d = irq;
      if (sense_clr) begin
         st_d  = '0;
         irq_d = 1'b0;
      end
      if (done_write) begin
         st_d[ST_XFER]  = 1'b1;
         st_d[ST_PRINT] = 1'b1;
      end
      if (done_ctrl) st_d[ST_CARR] = 1'b1;
      if (busy_hit)  st_d[ST_BUSY] = 1'b1;
      if (chan_bad)  st_d[ST_CHAN] = 1'b1;
      if (done_write || done_ctrl) irq_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         irq  <= 1'b0;
      end else begin
         st_q <= st_d;
         irq  <= irq_d;
      end
   end

   generate
      if (SENSE_REG_OUT) begin : g_sense_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sense_valid <= 1'b0;
               sense_dsw   <= '0;
            end else begin
               sense_valid <= req_sense;
               sense_dsw   <= req_sense ? st_q : '0;
            end
         end
      end else begin : g_sense_comb
         always_comb begin
            sense_valid = req_sense;
            sense_dsw   = req_sense ? st_q : '0;
         end
      end
   endgenerate

   AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_write || done_ctrl) |=> irq); // R4
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !sense_clr) |=> irq); // R7
   AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_clr && !done_write && !done_ctrl && !busy_hit && !chan_bad)
      |=> (!irq && st_q == '0)); // R6
   AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_clr) |=> ((st_q & $past(st_q)) == $past(st_q))); // R6
endmodule

// File: rtl/vlp_printer_ctrl.sv
module vlp_printer_ctrl
   import vlp_pkg::*;
#(
   parameter int MOD_W         = 5,
   parameter int NCHAN         = 12,
   parameter int DSW_W         = 16,
   parameter bit SENSE_REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_func,
   input  logic [MOD_W-1:0] cmd_mod,
   input  logic             sw_done,
   output logic             lf_new,
   output logic [2:0]       lf_func,
   output logic [MOD_W-1:0] lf_mod,
   output logic             carr_skip,
   output logic [MOD_W-2:0] carr_num,
   output logic             irq,
   output logic             sense_valid,
   output logic [DSW_W-1:0] sense_dsw
);
   localparam int VAL_W = MOD_W - 1;

   generate
      if (MOD_W < 2) begin : g_bad_mod
         $error("MOD_W must leave room for a skip flag and a value");
      end
      if (NCHAN < 1 || NCHAN >= (1 << VAL_W)) begin : g_bad_chan
         $error("NCHAN must fit in the modifier value field");
      end
      if (DSW_W < ST_MIN_W) begin : g_bad_dsw
         $error("DSW_W too narrow for the status bits");
      end
   endgenerate

   logic             req_write, req_ctrl, req_sense, sense_clr, chan_bad;
   logic             ctrl_skip;
   logic [VAL_W-1:0] ctrl_val;
   logic             busy_hit, done_write, done_ctrl;
   fn_t              lf_func_w;

   vlp_cmd_decode #(.MOD_W(MOD_W), .NCHAN(NCHAN)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_func  (fn_t'(cmd_func)),
      .cmd_mod   (cmd_mod),
      .req_write (req_write),
      .req_ctrl  (req_ctrl),
      .req_sense (req_sense),
      .sense_clr (sense_clr),
      .chan_bad  (chan_bad),
      .ctrl_skip (ctrl_skip),
      .ctrl_val  (ctrl_val)
   );

   vlp_func_reg #(.MOD_W(MOD_W)) u_freg (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_write  (req_write),
      .req_ctrl   (req_ctrl),
      .req_sense  (req_sense),
      .cmd_mod    (cmd_mod),
      .ctrl_skip  (ctrl_skip),
      .ctrl_val   (ctrl_val),
      .sw_done    (sw_done),
      .lf_new     (lf_new),
      .lf_func    (lf_func_w),
      .lf_mod     (lf_mod),
      .carr_skip  (carr_skip),
      .carr_num   (carr_num),
      .busy_hit   (busy_hit),
      .done_write (done_write),
      .done_ctrl  (done_ctrl)
   );

   assign lf_func = lf_func_w;

   vlp_status #(.DSW_W(DSW_W), .SENSE_REG_OUT(SENSE_REG_OUT)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_write  (done_write),
      .done_ctrl   (done_ctrl),
      .busy_hit    (busy_hit),
      .chan_bad    (chan_bad),
      .req_sense   (req_sense),
      .sense_clr   (sense_clr),
      .irq         (irq),
      .sense_valid (sense_valid),
      .sense_dsw   (sense_dsw)
   );

   AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      carr_skip |-> (carr_num >= VAL_W'(1) && carr_num <= VAL_W'(NCHAN))); // R9
   AST_BAD_NOT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_bad && !lf_new) |=> !lf_new); // R9
   AST_LOGGED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      lf_new |-> (lf_func == FN_WRITE || lf_func == FN_CTRL)); // R2
endmodule

// File: tb/vlp_printer_ctrl_tb.sv
module vlp_printer_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] F_CTRL  = 3'b100;
   localparam logic [2:0] F_WRITE = 3'b101;
   localparam logic [2:0] F_SENSE = 3'b111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_func = '0;
   logic [4:0]  cmd_mod = '0;
   logic        sw_done = 1'b0;
   logic        lf_new, carr_skip, irq, sense_valid;
   logic [2:0]  lf_func;
   logic [4:0]  lf_mod;
   logic [3:0]  carr_num;
   logic [15:0] sense_dsw;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vlp_printer_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
      .cmd_mod(cmd_mod), .sw_done(sw_done), .lf_new(lf_new), .lf_func(lf_func),
      .lf_mod(lf_mod), .carr_skip(carr_skip), .carr_num(carr_num), .irq(irq),
      .sense_valid(sense_valid), .sense_dsw(sense_dsw)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] f, input logic [4:0] m);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_func = f; cmd_mod = m;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_func = '0; cmd_mod = '0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      sw_done = 1'b1;
      @(negedge clk);
      sw_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 lf_new", lf_new, 0);
      check("R10 irq", irq, 0);
      check("R10 sense_valid", sense_valid, 0);
      check("R10 sense_dsw", sense_dsw, 0);
      check("R10 lf_func", lf_func, 0);
      check("R10 carr", {carr_skip, carr_num, lf_mod}, 0);
      rst_n = 1'b1;

      for (int f = 0; f < 8; f++) begin
         for (int m = 0; m < 32; m++) begin
            logic [2:0]  fv;
            logic [4:0]  mv;
            logic        is_w, is_c, is_s, bad, acc;
            logic [15:0] exp_dsw;
            fv = 3'(f); mv = 5'(m);
            issue(F_SENSE, 5'd1);
            check("R6 pre-clear irq", irq, 0);
            is_w = (fv == F_WRITE);
            is_c = (fv == F_CTRL);
            is_s = (fv == F_SENSE);
            bad  = is_c && mv[4] && (mv[3:0] == 0 || mv[3:0] > 12);
            acc  = is_w || (is_c && !bad);
            issue(fv, mv);
            check("R1 R2 R3 logged flag", lf_new, acc);
            check("R1 R6 sense strobe", sense_valid, is_s);
            check("R1 R9 irq quiet", irq, 0);
            if (acc) begin
               check("R2 lf_func", lf_func, fv);
               check("R2 lf_mod", lf_mod, mv);
               check("R9 carr_skip", carr_skip, is_c && mv[4]);
               check("R9 carr_num", carr_num, is_c ? mv[3:0] : 4'd0);
               done_pulse();
               check("R4 flag cleared", lf_new, 0);
               check("R4 irq raised", irq, 1);
               exp_dsw = is_w ? 16'h0003 : 16'h0004;
               issue(F_SENSE, 5'd0);
               check("R5 status word", sense_dsw, exp_dsw);
               check("R7 irq after plain sense", irq, 1);
               issue(F_SENSE, 5'd1);
               check("R6 status before reset", sense_dsw, exp_dsw);
               check("R6 R7 irq cleared", irq, 0);
            end else begin
               exp_dsw = bad ? 16'h0010 : 16'h0000;
               issue(F_SENSE, 5'd1);
               check("R9 R1 status", sense_dsw, exp_dsw);
            end
         end
      end

      // R8 busy: second request while pending
      issue(F_SENSE, 5'd1);
      issue(F_WRITE, 5'd7);
      issue(F_CTRL, 5'b10011);
      check("R8 func kept", lf_func, F_WRITE);
      check("R8 mod kept", lf_mod, 5'd7);
      check("R8 still pending", lf_new, 1);
      issue(F_SENSE, 5'd0);
      check("R8 busy bit", sense_dsw, 16'h0008);
      check("R3 sense not logged", lf_func, F_WRITE);
      done_pulse();
      issue(F_SENSE, 5'd1);
      check("R8 R5 bits after done", sense_dsw, 16'h000B);

      // R4 stray completion ignored
      done_pulse();
      check("R4 stray done irq", irq, 0);
      issue(F_SENSE, 5'd0);
      check("R4 stray done status", sense_dsw, 0);

      // R7 irq stays over idle cycles
      issue(F_CTRL, 5'd2);
      done_pulse();
      repeat (20) @(negedge clk);
      check("R7 irq held", irq, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule